// File: doc/BRIEF.md
# Transmit Buffer Descriptor List Walker

This block works through a list of transmit buffer descriptors held in host memory and assembles outgoing frames from the buffers those descriptors point at. Each descriptor is six 16-bit words. A flag word comes first. The next two words hold control bits and a 22-bit buffer address. A length word follows, and the last two words receive completion status. The walker reads each descriptor and marks it as in use. It copies the referenced bytes into a local frame store, then restores the flag word. When a descriptor marks the end of a frame, the walker streams the assembled frame out one byte per cycle and writes completion status into that descriptor.

The walk starts when the list base is presented together with a start pulse, and it runs until a descriptor is not valid. It also stops early when a descriptor or buffer would fall outside memory, or when a buffer is too large. Chain descriptors redirect the walk to another list. When the walk ends, the list is flagged invalid again, so that software must hand over a fresh list. Each completed frame sets a sticky transmit-done flag and, when enabled, pulses an interrupt request.

Memory is reached through a simple synchronous word port: read data returns the cycle after the request, and a write takes effect at the request edge.

Top module: `txdesc_walker`

## Requirements
- R1: While reset is held and after it is released, busy, done, interrupt, memory request and frame-valid outputs are low and the list-invalid output is high.
- R2: The buffer address is bits 5:0 of descriptor word 1 above word 2. The buffer byte count is twice the 16-bit two's complement negation of word 3. Bytes are gathered in ascending address order, and the even-address byte is the low half of a memory word, so an odd start address is handled byte by byte.
- R3: A descriptor whose word 1 bit 15 is clear ends the walk. No write is made to it.
- R4: For a valid descriptor, the walker first writes 0xFFFF to word 0. Later it writes back the originally read word 0 with bit 14 cleared.
- R5: When word 1 bit 14 is set, no bytes are gathered and the next descriptor is taken from the buffer address. Otherwise the next descriptor lies 12 bytes further on.
- R6: When word 1 bit 13 is set, the bytes gathered since the previous frame end leave on the frame output in order, with the last byte marked. Then word 4 is written 0x2000 and word 5 is written 0.
- R7: A frame end with no gathered bytes produces no frame output, but it still writes the status words.
- R8: A frame holds at most FRAME_MAX bytes (default 1514). Further buffer bytes are skipped.
- R9: A buffer longer than 2048 bytes, or one whose end passes MEM_BYTES, aborts the walk after the 0xFFFF mark. Word 0 is not restored and no status is written.
- R10: A descriptor whose 12 bytes would pass MEM_BYTES ends the walk without any memory access to it. The walker never addresses memory at or above MEM_BYTES.
- R11: Every frame end sets the done flag, which stays set until the clear input is pulsed. The interrupt request pulses for one cycle per frame end only while interrupts are enabled.
- R12: A start clears list-invalid, which remains clear while busy and is set when the walk ends. A start received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| list_word_i | input | ADDR_W-1 | List base as a 16-bit word address |
| irq_en_i | input | 1 | Interrupt enable |
| done_clr_i | input | 1 | Clears the done flag |
| busy_o | output | 1 | Walk in progress |
| list_invalid_o | output | 1 | No live list handed over |
| tx_done_o | output | 1 | Sticky frame-completed flag |
| irq_o | output | 1 | One-cycle interrupt request per frame end |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W-1 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after a read request |
| fo_valid_o | output | 1 | Frame byte valid |
| fo_data_o | output | 8 | Frame byte |
| fo_last_o | output | 1 | Final byte of the frame |

## Verification
Memory writes appear on the port in the same cycle the walker issues them. Frame bytes begin two cycles after the flag restore that precedes a frame end. The done flag and interrupt pulse show one cycle after the second status write, and list-invalid rises in the same cycle that busy falls. The bench's reference walk runs ahead of each start and queues every expected write and byte. The monitor then samples at the falling edge of each cycle and compares each port event against the head of its queue at the moment it appears. The flags are sampled in the first idle cycle, once busy has dropped.

// File: rtl/txw_pkg.sv
// Shared definitions for the transmit descriptor walker.
// Assumes 16-bit host memory words and six-word descriptors.
package txw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_FLAG,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_FETCH_LEN,
        ST_TAKE_LEN,
        ST_DECIDE,
        ST_GATHER_RD,
        ST_GATHER_WR,
        ST_RESTORE,
        ST_EMIT,
        ST_STAT1,
        ST_STAT2,
        ST_ADVANCE,
        ST_FINISH
    } walk_state_t;

    localparam int unsigned DESC_BYTES   = 12;
    localparam int unsigned BIT_VALID    = 15;
    localparam int unsigned BIT_CHAIN    = 14;
    localparam int unsigned BIT_EOF      = 13;
    localparam logic [15:0] MARK_BUSY    = 16'hFFFF;
    localparam logic [15:0] STATUS_OK    = 16'h2000;
    localparam logic [15:0] STATUS_CLEAR = 16'h0000;

endpackage

// File: rtl/desc_decode.sv
// Descriptor field decode.
// Builds the buffer address and byte count from the captured words, and flags
// buffers that are too long or would run past the end of memory.
// Assumes ADDR_W > 16 (high address bits come from word 1).
module desc_decode #(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned MEM_BYTES = 4194304,
    parameter int unsigned BUF_MAX   = 2048
) (
    input  logic [ADDR_W-17:0] addr_hi_i,
    input  logic [15:0]        addr_lo_i,
    input  logic [15:0]        len_word_i,
    output logic [ADDR_W-1:0]  buf_addr_o,
    output logic [16:0]        buf_bytes_o,
    output logic               too_long_o,
    output logic               overrun_o
);
    localparam int unsigned SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] MEM_LIM = SUM_W'(MEM_BYTES);
    localparam logic [16:0]      LEN_LIM = 17'(BUF_MAX);

    logic [15:0] neg_words;

    // Negated word count to bytes, then the range checks.
    always_comb begin
        neg_words   = 16'(~len_word_i + 16'd1);
        buf_addr_o  = {addr_hi_i, addr_lo_i};
        buf_bytes_o = {neg_words, 1'b0};
        too_long_o  = buf_bytes_o > LEN_LIM;
        overrun_o   = (SUM_W'(buf_addr_o) + SUM_W'(buf_bytes_o)) > MEM_LIM;
    end
endmodule

// File: rtl/frame_store.sv
// Byte store holding one frame between gather and hand-off.
// One write port and one registered read port. No reset on the contents.
module frame_store #(
    parameter int unsigned DEPTH = 1514,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o
);
    logic [7:0] bytes_q [DEPTH];

    // Capture one gathered byte.
    always_ff @(posedge clk) begin
        if (wr_en_i) bytes_q[wr_addr_i] <= wr_data_i;
    end

    // Registered read for the emitter.
    always_ff @(posedge clk) begin
        if (rd_en_i) rd_data_o <= bytes_q[rd_addr_i];
    end
endmodule

// File: rtl/frame_emitter.sv
// Streams len_i bytes from the frame store after a go pulse.
// Output valid trails the read by one cycle, matching the store's read latency.
// Assumes len_i is non-zero when go_i is pulsed.
module frame_emitter #(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned RA_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             rd_en_o,
    output logic [RA_W-1:0]  rd_addr_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             done_o
);
    logic             active_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] len_q;
    logic             v_q;
    logic             l_q;
    logic             final_w;

    // Marks the read of the final byte.
    always_comb begin
        final_w = active_q && (idx_q == len_q - CNT_W'(1));
    end

    // Read sequencing and the output pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
            v_q      <= 1'b0;
            l_q      <= 1'b0;
        end else begin
            v_q <= active_q;
            l_q <= final_w;
            if (go_i) begin
                active_q <= 1'b1;
                idx_q    <= '0;
                len_q    <= len_i;
            end else if (active_q) begin
                idx_q <= idx_q + CNT_W'(1);
                if (final_w) active_q <= 1'b0;
            end
        end
    end

    assign rd_en_o   = active_q;
    assign rd_addr_o = RA_W'(idx_q);
    assign valid_o   = v_q;
    assign last_o    = v_q & l_q;
    assign done_o    = v_q & l_q;
endmodule

// File: rtl/txdesc_walker.sv
// Transmit buffer descriptor list walker.
// Fetches six-word descriptors, gathers the buffer bytes into a frame, emits the
// frame at each frame-end descriptor, and writes busy marks and status back.
// Assumes memory read data arrives one cycle after the request and that
// descriptors are word aligned (addresses are carried as word addresses).
module txdesc_walker
    import txw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned MEM_BYTES = 4194304,
    parameter int unsigned FRAME_MAX = 1514,
    parameter int unsigned BUF_MAX   = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-2:0] list_word_i,
    input  logic              irq_en_i,
    input  logic              done_clr_i,
    output logic              busy_o,
    output logic              list_invalid_o,
    output logic              tx_done_o,
    output logic              irq_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-2:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic [15:0]       mem_rdata_i,
    output logic              fo_valid_o,
    output logic [7:0]        fo_data_o,
    output logic              fo_last_o
);
    localparam int unsigned WA_W   = ADDR_W - 1;
    localparam int unsigned HI_W   = ADDR_W - 16;
    localparam int unsigned SUM_W  = ADDR_W + 2;
    localparam int unsigned CNT_W  = $clog2(FRAME_MAX + 1);
    localparam int unsigned SA_W   = $clog2(FRAME_MAX);
    localparam logic [SUM_W-1:0] MEM_LIM   = SUM_W'(MEM_BYTES);
    localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(FRAME_MAX);

    walk_state_t      state_q;
    logic [WA_W-1:0]  desc_q;
    logic [15:0]      flag_q;
    logic             f_valid_q;
    logic             f_chain_q;
    logic             f_eof_q;
    logic [HI_W-1:0]  addr_hi_q;
    logic [15:0]      addr_lo_q;
    logic [15:0]      len_q;
    logic [16:0]      gidx_q;
    logic [CNT_W-1:0] fcnt_q;
    logic             sel_q;
    logic             done_q;
    logic             irq_q;
    logic             linv_q;

    logic [ADDR_W-1:0] buf_addr;
    logic [16:0]       buf_bytes;
    logic              too_long;
    logic              overrun;
    logic              desc_fits;
    logic              gather_stop;
    logic [ADDR_W-1:0] cur_byte;
    logic              emit_go;
    logic              emit_done;
    logic              st_rd_en;
    logic [SA_W-1:0]   st_rd_addr;
    logic              st_we;
    logic [7:0]        st_wdata;

    desc_decode #(
        .ADDR_W   (ADDR_W),
        .MEM_BYTES(MEM_BYTES),
        .BUF_MAX  (BUF_MAX)
    ) decode_i (
        .addr_hi_i  (addr_hi_q),
        .addr_lo_i  (addr_lo_q),
        .len_word_i (len_q),
        .buf_addr_o (buf_addr),
        .buf_bytes_o(buf_bytes),
        .too_long_o (too_long),
        .overrun_o  (overrun)
    );

    frame_store #(
        .DEPTH(FRAME_MAX),
        .AW   (SA_W)
    ) store_i (
        .clk      (clk),
        .wr_en_i  (st_we),
        .wr_addr_i(SA_W'(fcnt_q)),
        .wr_data_i(st_wdata),
        .rd_en_i  (st_rd_en),
        .rd_addr_i(st_rd_addr),
        .rd_data_o(fo_data_o)
    );

    frame_emitter #(
        .CNT_W(CNT_W),
        .RA_W (SA_W)
    ) emit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (emit_go),
        .len_i    (fcnt_q),
        .rd_en_o  (st_rd_en),
        .rd_addr_o(st_rd_addr),
        .valid_o  (fo_valid_o),
        .last_o   (fo_last_o),
        .done_o   (emit_done)
    );

    // Range test, gather address and store-side controls.
    always_comb begin
        desc_fits   = (SUM_W'({desc_q, 1'b0}) + SUM_W'(DESC_BYTES)) <= MEM_LIM;
        cur_byte    = buf_addr + ADDR_W'(gidx_q);
        gather_stop = (gidx_q == buf_bytes) || (fcnt_q == FRAME_LIM);
        st_we       = (state_q == ST_GATHER_WR);
        st_wdata    = sel_q ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
        emit_go     = (state_q == ST_RESTORE) && f_eof_q && (fcnt_q != '0);
    end

    // Memory port request for the current state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = desc_q;
        mem_wdata_o = STATUS_CLEAR;
        unique case (state_q)
            ST_FETCH_FLAG: mem_req_o = desc_fits;
            ST_FETCH_HI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + WA_W'(1);
            end
            ST_FETCH_LO: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + WA_W'(2);
            end
            ST_FETCH_LEN: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + WA_W'(3);
            end
            ST_DECIDE: begin
                mem_req_o   = f_valid_q;
                mem_we_o    = f_valid_q;
                mem_wdata_o = MARK_BUSY;
            end
            ST_GATHER_RD: begin
                mem_req_o  = !gather_stop;
                mem_addr_o = cur_byte[ADDR_W-1:1];
            end
            ST_RESTORE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = flag_q & ~(16'h0001 << BIT_CHAIN);
            end
            ST_STAT1: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + WA_W'(4);
                mem_wdata_o = STATUS_OK;
            end
            ST_STAT2: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + WA_W'(5);
                mem_wdata_o = STATUS_CLEAR;
            end
            default: ;
        endcase
    end

    // Walk sequencer, captured descriptor words, counters and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            desc_q    <= '0;
            flag_q    <= '0;
            f_valid_q <= 1'b0;
            f_chain_q <= 1'b0;
            f_eof_q   <= 1'b0;
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            len_q     <= '0;
            gidx_q    <= '0;
            fcnt_q    <= '0;
            sel_q     <= 1'b0;
            done_q    <= 1'b0;
            irq_q     <= 1'b0;
            linv_q    <= 1'b1;
        end else begin
            irq_q <= 1'b0;
            if (done_clr_i) done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        desc_q  <= list_word_i;
                        linv_q  <= 1'b0;
                        fcnt_q  <= '0;
                        state_q <= ST_FETCH_FLAG;
                    end
                end
                ST_FETCH_FLAG: state_q <= desc_fits ? ST_FETCH_HI : ST_FINISH;
                ST_FETCH_HI: begin
                    flag_q  <= mem_rdata_i;
                    state_q <= ST_FETCH_LO;
                end
                ST_FETCH_LO: begin
                    f_valid_q <= mem_rdata_i[BIT_VALID];
                    f_chain_q <= mem_rdata_i[BIT_CHAIN];
                    f_eof_q   <= mem_rdata_i[BIT_EOF];
                    addr_hi_q <= mem_rdata_i[HI_W-1:0];
                    state_q   <= ST_FETCH_LEN;
                end
                ST_FETCH_LEN: begin
                    addr_lo_q <= mem_rdata_i;
                    state_q   <= ST_TAKE_LEN;
                end
                ST_TAKE_LEN: begin
                    len_q   <= mem_rdata_i;
                    state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    gidx_q <= '0;
                    if (!f_valid_q)               state_q <= ST_FINISH;
                    else if (f_chain_q)           state_q <= ST_RESTORE;
                    else if (too_long || overrun) state_q <= ST_FINISH;
                    else                          state_q <= ST_GATHER_RD;
                end
                ST_GATHER_RD: begin
                    sel_q   <= cur_byte[0];
                    state_q <= gather_stop ? ST_RESTORE : ST_GATHER_WR;
                end
                ST_GATHER_WR: begin
                    fcnt_q  <= fcnt_q + CNT_W'(1);
                    gidx_q  <= gidx_q + 17'd1;
                    state_q <= ST_GATHER_RD;
                end
                ST_RESTORE: begin
                    if (!f_eof_q)          state_q <= ST_ADVANCE;
                    else if (fcnt_q != '0) state_q <= ST_EMIT;
                    else                   state_q <= ST_STAT1;
                end
                ST_EMIT:  if (emit_done) state_q <= ST_STAT1;
                ST_STAT1: state_q <= ST_STAT2;
                ST_STAT2: begin
                    done_q  <= 1'b1;
                    irq_q   <= irq_en_i;
                    fcnt_q  <= '0;
                    state_q <= ST_ADVANCE;
                end
                ST_ADVANCE: begin
                    desc_q  <= f_chain_q ? buf_addr[ADDR_W-1:1] : desc_q + WA_W'(DESC_BYTES / 2);
                    state_q <= ST_FETCH_FLAG;
                end
                ST_FINISH: begin
                    linv_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o         = (state_q != ST_IDLE);
    assign list_invalid_o = linv_q;
    assign tx_done_o      = done_q;
    assign irq_o          = irq_q;
endmodule

// File: rtl/txdesc_walker_chk.sv
// Property checker for the descriptor walker, bound to every instance.
// Observes ports only and keeps one frame-length counter of its own.
module txdesc_walker_chk #(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned MEM_BYTES = 4194304,
    parameter int unsigned FRAME_MAX = 1514
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en_i,
    input logic              busy_o,
    input logic              list_invalid_o,
    input logic              tx_done_o,
    input logic              irq_o,
    input logic              mem_req_o,
    input logic [ADDR_W-2:0] mem_addr_o,
    input logic              fo_valid_o,
    input logic              fo_last_o
);
    localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W + 1)'(MEM_BYTES);

    logic [31:0] frame_bytes_q;

    // Bytes seen so far in the frame on the output.
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_bytes_q <= '0;
        else if (fo_valid_o) frame_bytes_q <= fo_last_o ? '0 : frame_bytes_q + 32'd1;
    end

    // R12
    linv_clear_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !list_invalid_o);

    // R11
    irq_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> tx_done_o);

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq_en_i));

    // R10
    mem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ({mem_addr_o, 1'b0} < MEM_LIM));

    // R6
    frame_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid_o |-> busy_o);

    // R8
    frame_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid_o |-> (frame_bytes_q < 32'(FRAME_MAX)));
endmodule

bind txdesc_walker txdesc_walker_chk #(
    .ADDR_W   (ADDR_W),
    .MEM_BYTES(MEM_BYTES),
    .FRAME_MAX(FRAME_MAX)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_en_i      (irq_en_i),
    .busy_o        (busy_o),
    .list_invalid_o(list_invalid_o),
    .tx_done_o     (tx_done_o),
    .irq_o         (irq_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .fo_valid_o    (fo_valid_o),
    .fo_last_o     (fo_last_o)
);

// File: tb/txdesc_walker_tb_top.sv
// Bench for the descriptor walker. A behavioural reference walk queues every
// expected memory write and frame byte; a falling-edge monitor compares each
// port event with the queue heads as it happens.
module txdesc_walker_tb_top;
    localparam int ADDR_W    = 22;
    localparam int MEM_BYTES = 8192;
    localparam int FRAME_MAX = 1514;
    localparam int NWORDS    = MEM_BYTES / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-2:0] list_word_i = '0;
    logic              irq_en_i = 1'b0;
    logic              done_clr_i = 1'b0;
    logic              busy_o, list_invalid_o, tx_done_o, irq_o;
    logic              mem_req_o, mem_we_o;
    logic [ADDR_W-2:0] mem_addr_o;
    logic [15:0]       mem_wdata_o;
    logic [15:0]       mem_rdata_i = '0;
    logic              fo_valid_o, fo_last_o;
    logic [7:0]        fo_data_o;

    logic [15:0] mem [NWORDS];
    int          mm  [NWORDS];
    int exp_wa[$], exp_wd[$], exp_b[$], exp_l[$];
    int total = 0, fails = 0, irq_seen = 0, cyc = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    txdesc_walker #(
        .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .FRAME_MAX(FRAME_MAX), .BUF_MAX(2048)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_word_i(list_word_i),
        .irq_en_i(irq_en_i), .done_clr_i(done_clr_i), .busy_o(busy_o),
        .list_invalid_o(list_invalid_o), .tx_done_o(tx_done_o), .irq_o(irq_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .fo_valid_o(fo_valid_o), .fo_data_o(fo_data_o), .fo_last_o(fo_last_o)
    );

    // Host memory: reads return next cycle, writes land at the edge.
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;
            else          mem_rdata_i <= mem[mem_addr_o[11:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of port events with the reference queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o) irq_seen++;
            if (mem_req_o && mem_we_o) begin
                if (exp_wa.size() == 0) chk(0, tag, "unexpected write", {mem_addr_o, 1'b0}, -1);
                else begin
                    int a, d;
                    a = exp_wa.pop_front();
                    d = exp_wd.pop_front();
                    chk(({mem_addr_o, 1'b0} == a), tag, "write address", {mem_addr_o, 1'b0}, a);
                    chk((mem_wdata_o == d), tag, "write data", mem_wdata_o, d);
                end
            end
            if (fo_valid_o) begin
                if (exp_b.size() == 0) chk(0, tag, "unexpected frame byte", fo_data_o, -1);
                else begin
                    int b, l;
                    b = exp_b.pop_front();
                    l = exp_l.pop_front();
                    chk((fo_data_o == b && fo_last_o == l), tag, "frame byte/last",
                        {fo_last_o, fo_data_o}, (l << 8) | b);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL R12 watchdog: actual hung expected walk end");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic put_word(input int a, input int v);
        mm[a >> 1]  = v & 16'hFFFF;
        mem[a >> 1] = 16'(v);
    endtask

    task automatic put_byte(input int x, input int v);
        int w;
        w = mm[x >> 1];
        if (x & 1) w = (w & 8'hFF) | ((v & 8'hFF) << 8);
        else       w = (w & 16'hFF00) | (v & 8'hFF);
        put_word(x & ~1, w);
    endtask

    task automatic fill(input int a, input int n, input int seed);
        for (int i = 0; i < n; i++) put_byte(a + i, seed + i * 7);
    endtask

    task automatic put_desc(input int d, input int flag, input int ph, input int pl, input int ln);
        put_word(d, flag);      put_word(d + 2, ph);      put_word(d + 4, pl);
        put_word(d + 6, ln);    put_word(d + 8, 16'h1111); put_word(d + 10, 16'h2222);
    endtask

    // Reference walk over the model memory; returns the frame-end count.
    function automatic int model_walk(input int base);
        int d, eofs, flag, ph, pl, ln, addr, nb;
        int fb[$];
        d = base & ~1;
        eofs = 0;
        forever begin
            if (d + 12 > MEM_BYTES) break;                         // R10
            flag = mm[d >> 1]; ph = mm[(d >> 1) + 1];
            pl = mm[(d >> 1) + 2]; ln = mm[(d >> 1) + 3];
            if (((ph >> 15) & 1) == 0) break;                      // R3
            exp_wa.push_back(d); exp_wd.push_back(16'hFFFF); mm[d >> 1] = 16'hFFFF;
            addr = ((ph & 63) << 16) | pl;                         // R2
            nb = (((~ln) + 1) & 16'hFFFF) * 2;
            if (((ph >> 14) & 1) == 0) begin
                if (nb > 2048 || addr + nb > MEM_BYTES) break;     // R9
                for (int i = 0; i < nb && fb.size() < FRAME_MAX; i++)
                    fb.push_back((mm[(addr + i) >> 1] >> (((addr + i) & 1) * 8)) & 8'hFF);
            end
            exp_wa.push_back(d); exp_wd.push_back(flag & ~16'h4000);  // R4
            mm[d >> 1] = flag & ~16'h4000;
            if ((ph >> 13) & 1) begin                              // R6
                for (int i = 0; i < fb.size(); i++) begin
                    exp_b.push_back(fb[i]);
                    exp_l.push_back(i == fb.size() - 1);
                end
                fb.delete();
                exp_wa.push_back(d + 8);  exp_wd.push_back(16'h2000); mm[(d >> 1) + 4] = 16'h2000;
                exp_wa.push_back(d + 10); exp_wd.push_back(0);        mm[(d >> 1) + 5] = 0;
                eofs++;
            end
            d = ((ph >> 14) & 1) ? (addr & ~1) : d + 12;           // R5
        end
        return eofs;
    endfunction

    task automatic run_walk(input int base, input bit ie, input string req, input int poke);
        int eofs, guard;
        tag = req;
        @(negedge clk) done_clr_i = 1'b1;
        @(negedge clk) done_clr_i = 1'b0;
        chk(!tx_done_o, "R11", "done after clear", tx_done_o, 0);
        irq_seen = 0;
        eofs = model_walk(base);
        irq_en_i = ie;
        list_word_i = 21'(base >> 1);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o && !list_invalid_o, "R12", "busy/list-invalid after start",
            {busy_o, list_invalid_o}, 2);
        if (poke >= 0) begin
            list_word_i = 21'(poke >> 1);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(list_invalid_o, "R12", "list-invalid after walk", list_invalid_o, 1);
        chk(exp_wa.size() == 0, req, "writes outstanding", exp_wa.size(), 0);
        chk(exp_b.size() == 0, req, "frame bytes outstanding", exp_b.size(), 0);
        chk(tx_done_o == (eofs > 0), "R11", "done flag", tx_done_o, eofs > 0);
        chk(irq_seen == (ie ? eofs : 0), "R11", "interrupt pulses", irq_seen, ie ? eofs : 0);
        exp_wa.delete(); exp_wd.delete(); exp_b.delete(); exp_l.delete();
    endtask

    initial begin
        for (int i = 0; i < NWORDS; i++) begin mem[i] = '0; mm[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(!busy_o && list_invalid_o && !tx_done_o && !irq_o && !mem_req_o && !fo_valid_o,
            "R1", "reset outputs", {busy_o, list_invalid_o, tx_done_o, irq_o}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && list_invalid_o && !tx_done_o && !fo_valid_o, "R1", "after release",
            {busy_o, list_invalid_o, tx_done_o}, 2);

        // R2 R4 R6: one 6-byte buffer with frame end; R12 start while busy ignored
        put_desc(16'h0200, 16'h5555, 16'hA000, 16'h0F00, 16'hFFFE);
        put_desc(16'h0100, 16'h4321, 16'hA000, 16'h1000, 16'hFFFD);
        put_desc(16'h010C, 0, 0, 0, 0);
        fill(16'h1000, 6, 8'h30);
        run_walk(16'h0100, 1'b1, "R6", 16'h0200);
        chk(mem[16'h0200 >> 1] == 16'h5555, "R12", "poked list untouched", mem[16'h0200 >> 1], 16'h5555);

        // R2: odd start address, frame spans two buffers; R11 interrupts off
        put_desc(16'h0300, 16'h7000, 16'h8000, 16'h1101, 16'hFFFE);
        put_desc(16'h030C, 16'h0001, 16'hA000, 16'h1200, 16'hFFFD);
        put_desc(16'h0318, 0, 16'h0000, 0, 0);
        fill(16'h1101, 4, 8'h81);
        fill(16'h1200, 6, 8'hC4);
        run_walk(16'h0300, 1'b0, "R2", -1);

        // R5: chain to a second list
        put_desc(16'h0400, 16'h6000, 16'hC000, 16'h0500, 16'h0000);
        put_desc(16'h0500, 16'h0002, 16'hA000, 16'h1300, 16'hFFFC);
        put_desc(16'h050C, 0, 16'h4000, 0, 0);
        fill(16'h1300, 8, 8'h11);
        run_walk(16'h0400, 1'b1, "R5", -1);

        // R7: frame end with zero bytes
        put_desc(16'h0600, 16'h4000, 16'hA000, 16'h1000, 16'h0000);
        put_desc(16'h060C, 0, 0, 0, 0);
        run_walk(16'h0600, 1'b1, "R7", -1);

        // R9: buffer of 2050 bytes aborts; flag keeps the busy mark
        put_desc(16'h0700, 16'h4444, 16'hA000, 16'h1000, 16'hFBFF);
        run_walk(16'h0700, 1'b1, "R9", -1);
        chk(mem[16'h0700 >> 1] == 16'hFFFF, "R9", "flag left marked", mem[16'h0700 >> 1], 16'hFFFF);

        // R9: buffer running past end of memory
        put_desc(16'h0800, 16'h0004, 16'hA000, 16'h1F00, 16'hFF6A);
        run_walk(16'h0800, 1'b1, "R9", -1);
        chk(mem[(16'h0800 >> 1) + 4] == 16'h1111, "R9", "no status on abort",
            mem[(16'h0800 >> 1) + 4], 16'h1111);

        // R10: descriptor straddling the end of memory
        put_word(MEM_BYTES - 8, 16'hA000);
        run_walk(MEM_BYTES - 8, 1'b1, "R10", -1);

        // R3: invalid first descriptor
        put_desc(16'h0A00, 16'h1234, 16'h2000, 16'h1000, 16'hFFFD);
        run_walk(16'h0A00, 1'b1, "R3", -1);
        chk(mem[16'h0A00 >> 1] == 16'h1234, "R3", "invalid descriptor untouched",
            mem[16'h0A00 >> 1], 16'h1234);

        // R8: two 1024-byte buffers, frame capped
        put_desc(16'h0900, 16'h0000, 16'h8000, 16'h1400, 16'hFE00);
        put_desc(16'h090C, 16'h0000, 16'hA000, 16'h1800, 16'hFE00);
        put_desc(16'h0918, 0, 0, 0, 0);
        fill(16'h1400, 2048, 8'h05);
        run_walk(16'h0900, 1'b1, "R8", -1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule